// File: doc/BRIEF.md
# Interrupt and Mode Control Register Block

This block is a small 32-bit register file on a plain memory-mapped bus. It sits between six peripheral interrupt request lines and one processor interrupt input. It holds four words: a mode word, a fixed version word, a pending-interrupt status word and an interrupt-enable mask. Software never writes mode flags or mask bits directly. Each write carries command bits, and a separate clear bit and set bit exist for every flag. This lets one agent change a flag without a read-modify-write that could race another agent.

Each request input records a pending bit when it rises. The pending bit stays set until it is acknowledged. Sources 0 to 4 are acknowledged through a dedicated acknowledge input. Source 5, the display-processor source, is acknowledged only by a command bit in a mode write. The processor interrupt output is a registered OR over all sources of pending AND enabled.

Top module: `intc_regblk`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the mode, mask and status words read as zero, and `irq_out` and `rdata` are 0.
- R2: A word is selected when `addr[28:4]` equals `BASE_ADDR[28:4]` and `addr[1:0]` is 0. `addr[31:29]` is ignored. Byte offset 0x0 reads the mode word, 0x4 the `VERSION` parameter, 0x8 status (bits 5:0) and 0xC mask (bits 5:0). Read data appears on `rdata` one clock after `rd_en`.
- R3: A read of any address that is not selected returns 0. A write to such an address changes nothing.
- R4: Before any use, write data is ANDed with the byte lanes enabled by `wbe` (bit k enables bits 8k+7:8k).
- R5: A mode write replaces mode bits 6:0 with masked data bits 6:0.
- R6: Mode flags are init (bit 7), external-bus (bit 8) and memory-mode (bit 9). Their clear/set command bits in a mode write are 7/8, 9/10 and 12/13. Clear is applied before set, so when both are asserted the flag ends up set.
- R7: Mask bit n (n = 0..5) is cleared by write bit 2n and set by write bit 2n+1 of a write to 0xC. When both are asserted the bit ends up set.
- R8: Writes to offsets 0x4 and 0x8 change no register.
- R9: A 0-to-1 transition of `irq_req[n]` sets status bit n. A request held high does not set the bit again after it has been acknowledged.
- R10: `irq_ack[n]` clears status bit n for n = 0..4. A rising request in the same cycle takes priority, and the bit stays set.
- R11: Mode write bit 11 clears status bit 5 and touches no mode bit. `irq_ack` has no effect on status bit 5.
- R12: `irq_out` equals the OR of (status AND mask) as it stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 32 | Byte address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| wbe | input | 4 | Byte-lane write enables |
| rdata | output | 32 | Registered read data |
| irq_req | input | 6 | Peripheral interrupt requests |
| irq_ack | input | 5 | Acknowledge for sources 0 to 4 |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
The command-bit decoding is driven with several kinds of write word:
- Lone set bits and lone clear bits, which show that each command bit reaches the right flag.
- Words with both the clear and set bit of a pair, which separate clear-first ordering from set-first ordering.
- Words that mix field data with commands, which show that the low field and the flags are independent.
- Partial byte enables, which put command bits in disabled lanes and so show whether masking happens before decoding.

On the interrupt side, masked and unmasked sources show that the enable mask gates `irq_out`. An acknowledge given while a request is still held high separates edge capture from level capture. An acknowledge in the same cycle as a rise fixes which of the two wins. Aliased upper address bits, a misaligned address, and accesses outside the window exercise the decode.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC     = 6;
  localparam int DP_IDX   = 5;
  localparam int FIELD_W  = 7;
  localparam int NFLAG    = 3;
  localparam int MODE_W   = FIELD_W + NFLAG;
  localparam int DP_CLR_POS = 11;
  // flag order: init, external bus, memory mode
  localparam int FLAG_CLR [NFLAG] = '{7, 9, 12};
  localparam int FLAG_SET [NFLAG] = '{8, 10, 13};
  localparam logic [1:0] W_MODE = 2'd0;
  localparam logic [1:0] W_VER  = 2'd1;
  localparam logic [1:0] W_STAT = 2'd2;
  localparam logic [1:0] W_MASK = 2'd3;
endpackage

// File: rtl/intc_mode.sv
module intc_mode
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [13:0]       cmd,
  output logic [MODE_W-1:0] mode_q,
  output logic              dp_clr
);
  logic [MODE_W-1:0] mode_d;

  always_comb begin
    mode_d = mode_q;
    mode_d[FIELD_W-1:0] = cmd[FIELD_W-1:0];
  end

  generate
    for (genvar f = 0; f < NFLAG; f++) begin : g_flag
      logic nxt;
      always_comb begin
        nxt = mode_q[FIELD_W+f];
        if (cmd[FLAG_CLR[f]]) nxt = 1'b0;
        if (cmd[FLAG_SET[f]]) nxt = 1'b1;
      end
      always_ff @(posedge clk) begin
        if (rst)     mode_q[FIELD_W+f] <= 1'b0;
        else if (wr) mode_q[FIELD_W+f] <= nxt;
      end
      assert_flag_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (wr && cmd[FLAG_SET[f]]) |=> mode_q[FIELD_W+f]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)     mode_q[FIELD_W-1:0] <= '0;
    else if (wr) mode_q[FIELD_W-1:0] <= mode_d[FIELD_W-1:0];
  end

  assign dp_clr = wr & cmd[DP_CLR_POS];

  assert_field_load_R5: assert property (@(posedge clk) disable iff (rst)
    wr |=> mode_q[FIELD_W-1:0] == $past(cmd[FIELD_W-1:0]));
endmodule

// File: rtl/intc_mask.sv
module intc_mask
  import intc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [2*NSRC-1:0] cmd,
  output logic [NSRC-1:0] mask_q
);
  generate
    for (genvar n = 0; n < NSRC; n++) begin : g_src
      always_ff @(posedge clk) begin
        if (rst) mask_q[n] <= 1'b0;
        else if (wr) begin
          if (cmd[2*n+1])    mask_q[n] <= 1'b1;
          else if (cmd[2*n]) mask_q[n] <= 1'b0;
        end
      end
      assert_mask_set_R7: assert property (@(posedge clk) disable iff (rst)
        (wr && cmd[2*n+1]) |=> mask_q[n]);
      assert_mask_clr_R7: assert property (@(posedge clk) disable iff (rst)
        (wr && cmd[2*n] && !cmd[2*n+1]) |=> !mask_q[n]);
    end
  endgenerate
endmodule

// File: rtl/intc_status.sv
module intc_status
  import intc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-2:0] ack,
  input  logic            dp_clr,
  output logic [NSRC-1:0] status_q
);
  logic [NSRC-1:0] req_q;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] clr;

  assign rise = req & ~req_q;
  assign clr  = {dp_clr, ack};

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= '0;
      status_q <= '0;
    end else begin
      req_q    <= req;
      status_q <= (status_q & ~clr) | rise;
    end
  end

  assert_rise_sets_R9: assert property (@(posedge clk) disable iff (rst)
    (|rise) |=> ((status_q & $past(rise)) == $past(rise)));
  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (|(ack & ~rise[NSRC-2:0])) |=>
      ((status_q[NSRC-2:0] & $past(ack & ~rise[NSRC-2:0])) == '0));
  assert_dp_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (dp_clr && !rise[DP_IDX]) |=> !status_q[DP_IDX]);
endmodule

// File: rtl/intc_regblk.sv
module intc_regblk
  import intc_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h0200_0000,
  parameter logic [31:0] VERSION   = 32'h0A51_0003
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     addr,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [31:0]     wdata,
  input  logic [3:0]      wbe,
  output logic [31:0]     rdata,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-2:0] irq_ack,
  output logic            irq_out
);
  logic              sel;
  logic [1:0]        word;
  logic [31:0]       lane_mask;
  logic [31:0]       mdata;
  logic [31:0]       rd_mux;
  logic [MODE_W-1:0] mode_q;
  logic [NSRC-1:0]   mask_q;
  logic [NSRC-1:0]   status_q;
  logic              dp_clr;
  logic              unused_hi;

  assign unused_hi = ^{addr[31:29], wdata[31:14]};
  assign sel  = (addr[28:4] == BASE_ADDR[28:4]) && (addr[1:0] == 2'b00);
  assign word = addr[3:2];

  generate
    for (genvar b = 0; b < 4; b++) begin : g_lane
      assign lane_mask[8*b +: 8] = {8{wbe[b]}};
    end
  endgenerate
  assign mdata = wdata & lane_mask;

  intc_mode u_mode (
    .clk    (clk),
    .rst    (rst),
    .wr     (wr_en && sel && word == W_MODE),
    .cmd    (mdata[13:0]),
    .mode_q (mode_q),
    .dp_clr (dp_clr)
  );

  intc_mask u_mask (
    .clk    (clk),
    .rst    (rst),
    .wr     (wr_en && sel && word == W_MASK),
    .cmd    (mdata[2*NSRC-1:0]),
    .mask_q (mask_q)
  );

  intc_status u_status (
    .clk      (clk),
    .rst      (rst),
    .req      (irq_req),
    .ack      (irq_ack),
    .dp_clr   (dp_clr),
    .status_q (status_q)
  );

  always_comb begin
    rd_mux = '0;
    if (sel) begin
      case (word)
        W_MODE:  rd_mux = {{(32-MODE_W){1'b0}}, mode_q};
        W_VER:   rd_mux = VERSION;
        W_STAT:  rd_mux = {{(32-NSRC){1'b0}}, status_q};
        default: rd_mux = {{(32-NSRC){1'b0}}, mask_q};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      irq_out <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      irq_out <= |(status_q & mask_q);
    end
  end

  assert_irq_combine_R12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_out == $past(|(status_q & mask_q)));
  assert_unselected_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !sel) |=> rdata == 32'd0);
  assert_mode_read_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel && word == W_MODE) |=> rdata == {{(32-MODE_W){1'b0}}, $past(mode_q)});
  assert_version_read_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel && word == W_VER) |=> rdata == VERSION);
endmodule

// File: tb/test_intc_regblk.sv
module test_intc_regblk;
  localparam logic [31:0] BASE = 32'h0200_0000;
  localparam logic [31:0] VER  = 32'h0A51_0003;
  localparam int NV = 16;
  // {woff, wbe, wdata, roff, expected, requirement}
  localparam logic [91:0] VEC [NV] = '{
    {8'h00, 4'hF, 32'h0000_0055, 8'h00, 32'h0000_0055, 8'd5},  // R5
    {8'h00, 4'hF, 32'h0000_0100, 8'h00, 32'h0000_0080, 8'd6},  // R6 set init, field cleared
    {8'h00, 4'hF, 32'h0000_2403, 8'h00, 32'h0000_0383, 8'd6},  // R6 set ebus/mem
    {8'h00, 4'hF, 32'h0000_0180, 8'h00, 32'h0000_0380, 8'd6},  // R6 both -> set
    {8'h00, 4'hF, 32'h0000_1280, 8'h00, 32'h0000_0000, 8'd6},  // R6 clears
    {8'h00, 4'h1, 32'h0000_3F7F, 8'h00, 32'h0000_007F, 8'd4},  // R4 upper lane dropped
    {8'h00, 4'h2, 32'h0000_017F, 8'h00, 32'h0000_0080, 8'd4},  // R4 low lane dropped
    {8'h0C, 4'hF, 32'h0000_0AAA, 8'h0C, 32'h0000_003F, 8'd7},  // R7 all set
    {8'h0C, 4'hF, 32'h0000_0415, 8'h0C, 32'h0000_0018, 8'd7},  // R7 clears
    {8'h0C, 4'hF, 32'h0000_0C00, 8'h0C, 32'h0000_0038, 8'd7},  // R7 both -> set
    {8'h04, 4'hF, 32'hFFFF_FFFF, 8'h04, VER,           8'd8},  // R8
    {8'h04, 4'hF, 32'hFFFF_FFFF, 8'h00, 32'h0000_0080, 8'd8},  // R8
    {8'h08, 4'hF, 32'hFFFF_FFFF, 8'h0C, 32'h0000_0038, 8'd8},  // R8
    {8'h08, 4'hF, 32'hFFFF_FFFF, 8'h08, 32'h0000_0000, 8'd8},  // R8
    {8'h10, 4'hF, 32'hFFFF_FFFF, 8'h10, 32'h0000_0000, 8'd3},  // R3
    {8'h10, 4'hF, 32'hFFFF_FFFF, 8'h0C, 32'h0000_0038, 8'd3}   // R3
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] addr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  wbe = '0;
  logic [31:0] rdata;
  logic [5:0]  irq_req = '0;
  logic [4:0]  irq_ack = '0;
  logic        irq_out;
  int checks = 0;
  int bad = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  intc_regblk #(.BASE_ADDR(BASE), .VERSION(VER)) i_intc_regblk (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .wbe(wbe), .rdata(rdata), .irq_req(irq_req),
    .irq_ack(irq_ack), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    addr = a; wbe = be; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    checks++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 irq_out in reset", {31'd0, irq_out}, 32'd0);
    check("R1 rdata in reset", rdata, 32'd0);
    rst = 1'b0;
    rd(BASE + 32'h0, rv); check("R1 mode", rv, 32'd0);
    rd(BASE + 32'hC, rv); check("R1 mask", rv, 32'd0);
    rd(BASE + 32'h8, rv); check("R1 status", rv, 32'd0);

    for (int i = 0; i < NV; i++) begin
      wr(BASE + {24'd0, VEC[i][91:84]}, VEC[i][83:80], VEC[i][79:48]);
      rd(BASE + {24'd0, VEC[i][47:40]}, rv);
      check($sformatf("R%0d vector %0d", VEC[i][7:0], i), rv, VEC[i][39:8]);
    end

    // R2 alias through upper address bits
    rd({3'b111, BASE[28:0]} + 32'hC, rv); check("R2 aliased mask read", rv, 32'h38);
    wr({3'b101, BASE[28:0]}, 4'hF, 32'h0000_2000);
    rd(BASE, rv); check("R2 aliased mode write", rv, 32'h280);
    rd(BASE + 32'h2, rv); check("R3 misaligned read", rv, 32'd0);

    // mask = 0x38: sources 3,4,5 enabled
    @(negedge clk); irq_req[0] = 1'b1;
    tick(); irq_req[0] = 1'b0;
    tick(); check("R12 masked source no irq", {31'd0, irq_out}, 32'd0);
    rd(BASE + 32'h8, rv); check("R9 rise sets bit0", rv, 32'h01);

    @(negedge clk); irq_req[3] = 1'b1;
    tick(); tick(); check("R12 enabled source irq", {31'd0, irq_out}, 32'd1);
    rd(BASE + 32'h8, rv); check("R9 bit3 pending", rv, 32'h09);

    @(negedge clk); irq_ack[3] = 1'b1;
    tick(); irq_ack[3] = 1'b0;
    tick(); check("R12 irq drops after ack", {31'd0, irq_out}, 32'd0);
    rd(BASE + 32'h8, rv); check("R9 held level no re-set", rv, 32'h01);
    irq_req[3] = 1'b0;

    @(negedge clk); irq_ack[0] = 1'b1;
    tick(); irq_ack[0] = 1'b0;
    rd(BASE + 32'h8, rv); check("R10 ack clears bit0", rv, 32'h00);

    @(negedge clk); irq_req[1] = 1'b1; irq_ack[1] = 1'b1;
    tick(); irq_req[1] = 1'b0; irq_ack[1] = 1'b0;
    rd(BASE + 32'h8, rv); check("R10 rise beats ack", rv, 32'h02);
    @(negedge clk); irq_ack[1] = 1'b1;
    tick(); irq_ack[1] = 1'b0;
    rd(BASE + 32'h8, rv); check("R10 ack bit1", rv, 32'h00);

    @(negedge clk); irq_req[5] = 1'b1;
    tick(); irq_req[5] = 1'b0;
    tick(); check("R12 dp irq", {31'd0, irq_out}, 32'd1);
    @(negedge clk); irq_ack = 5'h1F;
    tick(); irq_ack = 5'h00;
    rd(BASE + 32'h8, rv); check("R11 ack ignores dp", rv, 32'h20);
    wr(BASE, 4'hF, 32'h0000_0800);
    rd(BASE + 32'h8, rv); check("R11 mode cmd clears dp", rv, 32'h00);
    check("R12 irq low after dp clear", {31'd0, irq_out}, 32'd0);
    rd(BASE, rv); check("R11 mode flags kept", rv, 32'h280);

    finish_run();
  end
endmodule